// File: doc/BRIEF.md
# Self-Test Engine for a Scan-Equipped Logic Core

This block tests a small sequential core from the inside, with no external tester. The core's flip-flops double as shift-register stages. When shifting is on, each stage takes its neighbour's bit in place of its functional next value. When shifting is off, the core runs its normal logic for one cycle.

After a start request the engine does four things. It draws bits from an on-chip maximal-length LFSR and shifts them into every chain. It drops shifting for a single capture cycle so the core computes one functional step. It folds every bit that leaves the chains into a multiple-input signature register. After the last pattern it runs one further unload so the final responses also enter the signature. Once the signature is complete, the engine raises a one-cycle done pulse and a pass flag. The flag tells whether the signature equals a golden word fixed at build time.

A fault-injection input forces one internal AND net of the core to a constant 0, which models a stuck-at-0 defect. This lets a user confirm that the engine reports a failure.

Top module: `lbist_ctrl`

## Requirements
- R1: Reset (rst_ni low) clears busy_o, done_o and pass_o to 0.
- R2: Suppose start_i is high at a rising edge while busy_o is low. Then busy_o is high from the next cycle on, for exactly N_PATTERNS*(CHAIN_LEN+1)+CHAIN_LEN+1 consecutive cycles.
- R3: done_o is high for exactly one cycle, which is the last cycle in which busy_o is high.
- R4: Let the LFSR, signature register and core be as in R7 and R8, and let GOLDEN equal the signature of a defect-free core. With fault_i low for the whole run, pass_o is 1 in the done cycle. With fault_i high for the whole run, it is 0.
- R5: pass_o is 0 from the cycle after an accepted start until done_o. It keeps its done-cycle value afterwards until the next accepted start.
- R6: A start_i pulse while busy_o is high has no effect. The run length and the result are unchanged.
- R7: Each pattern keeps shifting on for CHAIN_LEN cycles and then turns it off for exactly one capture cycle. A final unload of CHAIN_LEN shift cycles follows the last capture.
- R8: Pattern source is a 16-bit Fibonacci LFSR. It is seeded with SEED (default 16'hACE1) on start. It shifts left with feedback equal to the XOR of bits 15, 13, 12 and 10, and it advances on every shift cycle. Chain c takes LFSR bit c as its input. The signature register is cleared on start. On every shift cycle except those of the first pattern, it becomes {sig[14:0], XOR of bits 15,13,12,10} XOR a word whose bit c is chain c's output.
- R9: Core flop i (chain i/CHAIN_LEN, position i%CHAIN_LEN, output at the last position) captures q[i-1] XOR (q[i+1] AND q[i+2]), with indices taken modulo the flop count. fault_i forces the AND term of flop 0 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, honoured only when idle |
| fault_i | input | 1 | Forces the stuck-at-0 defect in the core |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle pulse in the last busy cycle |
| pass_o | output | 1 | Signature matched GOLDEN |

## Verification
Suppose the shift counter, pattern counter or state register goes wrong. The busy window then ends a cycle or more early or late, and the per-cycle comparison catches this at the first cycle where it differs. A wrong LFSR step, signature fold, chain link or capture equation does not appear until the done cycle, where pass_o takes the wrong value. For this reason every run is judged on its final flag against a signature computed independently in the bench, and the injected defect must turn a pass into a fail.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPT,
    ST_UNLOAD,
    ST_DONE
  } lbist_state_e;

  localparam logic [15:0] LFSR16_TAPS = 16'hB400;  // bits 15,13,12,10
endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
  parameter int          W     = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (load_i) q <= SEED;
    else if (step_i) q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign state_o = q;
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (clear_i) q <= '0;
    else if (en_i)    q <= {q[W-2:0], ^(q & TAPS)} ^ data_i;
  end

  assign sig_o = q;
endmodule

// File: rtl/lbist_cut.sv
module lbist_cut #(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scan_en_i,
  input  logic                  fault_i,
  input  logic [NUM_CHAINS-1:0] scan_in_i,
  output logic [NUM_CHAINS-1:0] scan_out_o
);
  localparam int NF = NUM_CHAINS * CHAIN_LEN;

  logic [NF-1:0] q, d;

  for (genvar i = 0; i < NF; i++) begin : g_ff
    localparam int K  = i % CHAIN_LEN;
    localparam int C  = i / CHAIN_LEN;
    localparam int IP = (i + NF - 1) % NF;
    localparam int I1 = (i + 1) % NF;
    localparam int I2 = (i + 2) % NF;
    logic and_net, d_scan, d_func;

    if (i == 0) begin : g_flt
      assign and_net = fault_i ? 1'b0 : (q[I1] & q[I2]);  // stuck-at-0 site
    end else begin : g_ok
      assign and_net = q[I1] & q[I2];
    end

    if (K == 0) begin : g_head
      assign d_scan = scan_in_i[C];
    end else begin : g_body
      assign d_scan = q[i-1];
    end

    assign d_func = q[IP] ^ and_net;
    assign d[i]   = scan_en_i ? d_scan : d_func;
  end

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_so
    assign scan_out_o[c] = q[c*CHAIN_LEN + CHAIN_LEN - 1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl #(
  parameter int               NUM_CHAINS = 2,
  parameter int               CHAIN_LEN  = 4,
  parameter int               N_PATTERNS = 100000,
  parameter int               SIG_W      = 16,
  parameter logic [SIG_W-1:0] SEED       = 16'hACE1,
  parameter logic [SIG_W-1:0] GOLDEN     = 16'h0000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fault_i,
  output logic busy_o,
  output logic done_o,
  output logic pass_o
);
  import lbist_pkg::*;

  localparam int SH_W  = $clog2(CHAIN_LEN + 1);
  localparam int PAT_W = $clog2(N_PATTERNS + 1);
  localparam logic [SH_W-1:0]  SH_LAST  = SH_W'(CHAIN_LEN - 1);
  localparam logic [PAT_W-1:0] PAT_LAST = PAT_W'(N_PATTERNS - 1);

  lbist_state_e     state_q;
  logic [SH_W-1:0]  sh_q;
  logic [PAT_W-1:0] pat_q;
  logic             pass_q;

  logic                  scan_en, accept, misr_en;
  logic [SIG_W-1:0]      prpg_q, sig_q, misr_din;
  logic [NUM_CHAINS-1:0] so;

  assign accept  = start_i && (state_q == ST_IDLE);
  assign scan_en = (state_q == ST_SHIFT) || (state_q == ST_UNLOAD);
  // first load flushes unknown core state: keep it out of the signature
  assign misr_en = (state_q == ST_UNLOAD) || ((state_q == ST_SHIFT) && (pat_q != '0));
  assign misr_din = {{(SIG_W-NUM_CHAINS){1'b0}}, so};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      pat_q   <= '0;
      pass_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_SHIFT;
          sh_q    <= '0;
          pat_q   <= '0;
          pass_q  <= 1'b0;
        end
        ST_SHIFT: begin
          if (sh_q == SH_LAST) begin
            sh_q    <= '0;
            state_q <= ST_CAPT;
          end else sh_q <= sh_q + 1'b1;
        end
        ST_CAPT: begin
          if (pat_q == PAT_LAST) state_q <= ST_UNLOAD;
          else begin
            pat_q   <= pat_q + 1'b1;
            state_q <= ST_SHIFT;
          end
        end
        ST_UNLOAD: begin
          if (sh_q == SH_LAST) begin
            sh_q    <= '0;
            state_q <= ST_DONE;
          end else sh_q <= sh_q + 1'b1;
        end
        ST_DONE: begin
          pass_q  <= (sig_q == GOLDEN);
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  lbist_prpg #(.W(SIG_W), .TAPS(lbist_pkg::LFSR16_TAPS), .SEED(SEED)) u_prpg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .step_i (scan_en),
    .state_o(prpg_q)
  );

  lbist_cut #(.NUM_CHAINS(NUM_CHAINS), .CHAIN_LEN(CHAIN_LEN)) u_cut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scan_en_i (scan_en),
    .fault_i   (fault_i),
    .scan_in_i (prpg_q[NUM_CHAINS-1:0]),
    .scan_out_o(so)
  );

  lbist_misr #(.W(SIG_W), .TAPS(lbist_pkg::LFSR16_TAPS)) u_misr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(accept),
    .en_i   (misr_en),
    .data_i (misr_din),
    .sig_o  (sig_q)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
  assign pass_o = done_o ? (sig_q == GOLDEN) : pass_q;
endmodule

// File: rtl/lbist_ctrl_sva.sv
module lbist_ctrl_sva #(
  parameter int CHAIN_LEN = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic pass_o,
  input logic scan_en_i
);
  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= 0;
    else if (scan_en_i) run_q <= run_q + 1;
    else                run_q <= 0;
  end

  a_r3_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_start_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o));
  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  a_r5_pass_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |-> !pass_o);
  a_r5_pass_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(pass_o));
  a_r7_shift_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_en_i && $past(scan_en_i)) |-> (run_q == CHAIN_LEN));
  a_r7_one_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !scan_en_i) |=> scan_en_i);
endmodule

bind lbist_ctrl lbist_ctrl_sva #(.CHAIN_LEN(CHAIN_LEN)) u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .pass_o   (pass_o),
  .scan_en_i(scan_en)
);

// File: tb/lbist_ctrl_bench.sv
module lbist_ctrl_bench;
  localparam int NC = 2;
  localparam int L  = 4;
  localparam int NP = 12;
  localparam int NF = NC * L;
  localparam logic [15:0] SEED_V = 16'hACE1;
  localparam int TOTAL = NP * (L + 1) + L + 1;

  // Behavioural signature of the whole run (R8, R9)
  function automatic logic [15:0] ref_sig(input bit flt);
    logic [NF-1:0] s, ns;
    logic [15:0] lf, ms, din;
    lf = SEED_V; ms = '0; s = '0;
    for (int p = 0; p <= NP; p++) begin
      for (int k = 0; k < L; k++) begin
        din = '0;
        for (int c = 0; c < NC; c++) din[c] = s[c*L + L - 1];
        if (p != 0) ms = {ms[14:0], ms[15] ^ ms[13] ^ ms[12] ^ ms[10]} ^ din;
        ns = s;
        for (int c = 0; c < NC; c++) begin
          for (int j = L - 1; j > 0; j--) ns[c*L + j] = s[c*L + j - 1];
          ns[c*L] = lf[c];
        end
        s  = ns;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      end
      if (p < NP) begin
        for (int i = 0; i < NF; i++) begin
          logic a;
          a = s[(i + 1) % NF] & s[(i + 2) % NF];
          if (flt && i == 0) a = 1'b0;
          ns[i] = s[(i + NF - 1) % NF] ^ a;
        end
        s = ns;
      end
    end
    return ms;
  endfunction

  localparam logic [15:0] GOLD = ref_sig(1'b0);

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, fault_i = 1'b0;
  logic busy_o, done_o, pass_o;
  int n_checks = 0, n_errors = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  lbist_ctrl #(.NUM_CHAINS(NC), .CHAIN_LEN(L), .N_PATTERNS(NP), .SIG_W(16),
               .SEED(SEED_V), .GOLDEN(GOLD)) u_lbist_ctrl (
    .clk_i, .rst_ni, .start_i, .fault_i, .busy_o, .done_o, .pass_o);

  // Reference model: cycles since accepted start
  bit running = 0, exp_res = 0, last_pass = 0, model_on = 0;
  int k = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      running = 0; k = 0; last_pass = 0;
    end else if (running) begin
      if (k == TOTAL - 1) begin running = 0; last_pass = exp_res; end
      else k++;
    end else if (start_i) begin
      running = 1; k = 0;
      exp_res = (ref_sig(fault_i) == GOLD);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (model_on && rst_ni) begin
      chk("R2", busy_o, running, "busy");
      chk("R3", done_o, running && (k == TOTAL - 1), "done");
      chk("R5", pass_o, running ? ((k == TOTAL - 1) ? exp_res : 1'b0) : last_pass, "pass");
    end
  end

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic wait_done(input string req, input logic exp_pass);
    int t = 0;
    while (done_o !== 1'b1 && t < 5000) begin @(negedge clk_i); t++; end
    chk(req, (t < 5000), 1'b1, "done seen");
    chk(req, pass_o, exp_pass, "pass at done");
    @(negedge clk_i);
  endtask

  initial begin
    #1;
    chk("R1", busy_o, 1'b0, "busy in reset");
    chk("R1", done_o, 1'b0, "done in reset");
    chk("R1", pass_o, 1'b0, "pass in reset");
    chk("R4", (ref_sig(1'b1) != GOLD), 1'b1, "defect visible in model");
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    model_on = 1;
    @(negedge clk_i);

    // R4 good core passes
    pulse_start();
    wait_done("R4", 1'b1);
    repeat (3) @(negedge clk_i);
    chk("R5", pass_o, 1'b1, "pass held after done");

    // R4 stuck-at-0 core fails
    fault_i = 1'b1;
    pulse_start();
    wait_done("R4", 1'b0);
    fault_i = 1'b0;

    // R6 start pulses while busy are ignored
    pulse_start();
    repeat (7) @(negedge clk_i);
    pulse_start();
    repeat (20) @(negedge clk_i);
    pulse_start();
    wait_done("R6", 1'b1);

    // R2 start held two cycles: second cycle ignored
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i) start_i = 1'b0;
    wait_done("R2", 1'b1);

    // R8 repeat run after a failing run still matches
    fault_i = 1'b1;
    pulse_start();
    wait_done("R8", 1'b0);
    fault_i = 1'b0;
    pulse_start();
    wait_done("R8", 1'b1);

    // R1 reset mid-run
    pulse_start();
    repeat (10) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1", busy_o, 1'b0, "busy after reset");
    chk("R1", pass_o, 1'b0, "pass after reset");
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule